// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block is the device side of a byte-wide parallel flash. It sits behind active-low chip-enable, output-enable and write-enable strobes, an address bus and an 8-bit data bus. The strobes are asynchronous to the system clock, so each one passes through a two-flop synchronizer. The data bus is split into an input, an output and an output-enable, and the enclosing pad ring merges them into one bidirectional bus. Each write cycle latches its address and data. A command state machine compares the sequence of write cycles against fixed unlock patterns. The array changes only after a complete and correct pattern, which then starts a byte program, a sector erase or a chip erase.

A started operation holds the decoder in a busy state for a set number of clock cycles. Program, sector erase and chip erase each have their own count, scaled far below real cell timing. While busy, a read returns status instead of array data. Bit 7 is the complement of bit 7 of the byte being written. Bit 6 inverts after every completed read cycle. Once the timer expires, the array update is applied and reads return stored data again.

The storage is a small register array of 2^ARR_W bytes, and addresses alias above that width. A sector is 2^SECT_W bytes. The default is scaled down to 64 bytes; SECT_W = 12 gives the 4 KB layout. The sector number is the array-address field from bit SECT_W up to the top bit.

The command state machine has these states:
- ST_IDLE: waits for a first unlock.
- ST_UNL1: first unlock seen.
- ST_UNL2: second unlock seen.
- ST_PGM_ARM: waits for the program target cycle.
- ST_ERS3: erase setup seen.
- ST_ERS4: fourth cycle seen.
- ST_ERS5: fifth cycle seen, waits for the erase selector.
- ST_BUSY: operation running.

Its transitions are:
- ST_IDLE→ST_UNL1 on 0x5555/0xAA.
- ST_UNL1→ST_UNL2 on 0x2AAA/0x55.
- ST_UNL2→ST_PGM_ARM on 0x5555/0xA0.
- ST_UNL2→ST_ERS3 on 0x5555/0x80.
- ST_PGM_ARM→ST_BUSY on any cycle.
- ST_ERS3→ST_ERS4 on 0x5555/0xAA.
- ST_ERS4→ST_ERS5 on 0x2AAA/0x55.
- ST_ERS5→ST_BUSY on data 0x30 (sector erase) or data 0x10 (chip erase).
- ST_BUSY→ST_IDLE when the timer finishes.
- Every other write cycle outside ST_BUSY returns the machine to ST_IDLE.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every array byte holds 0xFF, the data output is not driven (dq_oe = 0) and the decoder is idle.
- R2: dq_oe is 1 only when CE#, OE# and WE# synchronized read 0, 0 and 1. Outside busy, dq_out then carries the array byte at the low ARR_W address bits. With CE# high or OE# high, dq_oe is 0.
- R3: A write cycle runs while CE# and WE# are both low with OE# high. Its address and data are taken when the cycle ends. The cycle may be ended by WE# or by CE#, with the same result.
- R4: Program uses 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, then target/data. The stored byte becomes old AND new, so programming only clears bits.
- R5: Sector erase uses 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, then address/0x30. Every byte whose array address bits [ARR_W-1:SECT_W] equal those of the last cycle's address becomes 0xFF. No other byte changes.
- R6: Chip erase uses the same five-cycle prefix, then data 0x10 at any address. It sets every byte to 0xFF.
- R7: A write cycle that does not match the expected next cycle returns the decoder to idle with no change to the array.
- R8: The busy period lasts PROG_CYC, SECT_CYC or CHIP_CYC clock cycles. Write cycles during the busy period are ignored, including partial command sequences.
- R9: A read while busy returns bit 7 as the complement of bit 7 of the written byte (0xFF for erases), bit 6 as a toggle, and bits 5..0 as zero. The toggle inverts at the end of each read cycle taken while busy.
- R10: After the operation completes, reads return array data and bit 6 stops toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data bus, inbound half |
| dq_out | output | 8 | Data bus, outbound half (array byte or status) |
| dq_oe | output | 1 | Drive enable for the outbound data |

## Verification
The checker watches several properties on every clock:
- dq_oe is raised only two cycles after the raw pins form a read.
- Status bits 5..0 are zero whenever a busy read is driven.
- The toggle inverts after each busy read and holds still when not busy.
- The timer's completion occurs only inside the busy state, and busy lasts until that completion.

Only the bench scenarios can show the effect of a command on the array: AND-programming, sector boundaries of an erase, an aborted or ignored sequence leaving data untouched, and the matching of status bit 7 to the written byte.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    localparam int CMD_AW = 15;
    localparam logic [CMD_AW-1:0] ADR_A = 15'h5555;
    localparam logic [CMD_AW-1:0] ADR_B = 15'h2AAA;
    localparam logic [7:0] D_UNL1  = 8'hAA;
    localparam logic [7:0] D_UNL2  = 8'h55;
    localparam logic [7:0] D_PGM   = 8'hA0;
    localparam logic [7:0] D_ERS   = 8'h80;
    localparam logic [7:0] D_SECT  = 8'h30;
    localparam logic [7:0] D_CHIP  = 8'h10;

    typedef enum logic [2:0] {
        ST_IDLE, ST_UNL1, ST_UNL2, ST_PGM_ARM,
        ST_ERS3, ST_ERS4, ST_ERS5, ST_BUSY
    } fsm_st_t;

    typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SECT, OP_CHIP} op_t;
endpackage

// File: rtl/flash_bus_if.sv
module flash_bus_if #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        strb_n,   // {ce_n, oe_n, we_n}
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic              rd_act,
    output logic              rd_end,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [7:0]        cyc_data
);
    logic [2:0] s1, s2;
    logic wr_act, wr_act_q, rd_act_q;

    for (genvar g = 0; g < 3; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1[g] <= 1'b1;
                s2[g] <= 1'b1;
            end else begin
                s1[g] <= strb_n[g];
                s2[g] <= s1[g];
            end
        end
    end

    assign wr_act   = !s2[2] && s2[1] && !s2[0];
    assign rd_act   = !s2[2] && !s2[1] && s2[0];
    assign wr_pulse = wr_act_q && !wr_act;
    assign rd_end   = rd_act_q && !rd_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            rd_act_q <= 1'b0;
            cyc_addr <= '0;
            cyc_data <= '0;
        end else begin
            wr_act_q <= wr_act;
            rd_act_q <= rd_act;
            if (wr_act) begin
                cyc_addr <= addr;
                cyc_data <= dq_in;
            end
        end
    end
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] dur,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= dur;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == CNT_W'(1));
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int ARR_W    = 9,
    parameter int CNT_W    = 7,
    parameter int PROG_CYC = 40,
    parameter int SECT_CYC = 60,
    parameter int CHIP_CYC = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [7:0]        cyc_data,
    input  logic              done,
    output logic              busy,
    output logic              start,
    output logic [CNT_W-1:0]  start_dur,
    output op_t               op,
    output logic [ARR_W-1:0]  tgt_addr,
    output logic [7:0]        tgt_data
);
    fsm_st_t st, nxt;
    logic hit_a, hit_b;

    assign hit_a = (cyc_addr[CMD_AW-1:0] == ADR_A);
    assign hit_b = (cyc_addr[CMD_AW-1:0] == ADR_B);
    assign busy  = (st == ST_BUSY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:    if (wr_pulse) nxt = (hit_a && cyc_data == D_UNL1) ? ST_UNL1 : ST_IDLE;
            ST_UNL1:    if (wr_pulse) nxt = (hit_b && cyc_data == D_UNL2) ? ST_UNL2 : ST_IDLE;
            ST_UNL2:    if (wr_pulse) begin
                            if (hit_a && cyc_data == D_PGM)      nxt = ST_PGM_ARM;
                            else if (hit_a && cyc_data == D_ERS) nxt = ST_ERS3;
                            else                                 nxt = ST_IDLE;
                        end
            ST_PGM_ARM: if (wr_pulse) nxt = ST_BUSY;
            ST_ERS3:    if (wr_pulse) nxt = (hit_a && cyc_data == D_UNL1) ? ST_ERS4 : ST_IDLE;
            ST_ERS4:    if (wr_pulse) nxt = (hit_b && cyc_data == D_UNL2) ? ST_ERS5 : ST_IDLE;
            ST_ERS5:    if (wr_pulse) nxt = (cyc_data == D_SECT || cyc_data == D_CHIP) ? ST_BUSY : ST_IDLE;
            ST_BUSY:    if (done) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start     <= 1'b0;
            start_dur <= '0;
            op        <= OP_NONE;
            tgt_addr  <= '0;
            tgt_data  <= 8'hFF;
        end else begin
            start <= 1'b0;
            if (nxt == ST_BUSY && st != ST_BUSY) begin
                start    <= 1'b1;
                tgt_addr <= cyc_addr[ARR_W-1:0];
                if (st == ST_PGM_ARM) begin
                    op        <= OP_PROG;
                    tgt_data  <= cyc_data;
                    start_dur <= CNT_W'(PROG_CYC);
                end else if (cyc_data == D_SECT) begin
                    op        <= OP_SECT;
                    tgt_data  <= 8'hFF;
                    start_dur <= CNT_W'(SECT_CYC);
                end else begin
                    op        <= OP_CHIP;
                    tgt_data  <= 8'hFF;
                    start_dur <= CNT_W'(CHIP_CYC);
                end
            end
        end
    end
endmodule

// File: rtl/flash_store.sv
module flash_store
    import flash_cmd_pkg::*;
#(
    parameter int ARR_W  = 9,
    parameter int SECT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  op_t              op,
    input  logic [ARR_W-1:0] tgt_addr,
    input  logic [7:0]       tgt_data,
    input  logic [ARR_W-1:0] rd_addr,
    input  logic             busy,
    input  logic             rd_end,
    output logic             tog,
    output logic [7:0]       rdata
);
    localparam int DEPTH = 1 << ARR_W;

    logic [7:0] mem [DEPTH];
    logic [ARR_W-SECT_W-1:0] sect_sel;

    assign sect_sel = tgt_addr[ARR_W-1:SECT_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (op == OP_CHIP || (op == OP_SECT && (i >> SECT_W) == int'(sect_sel)))
                    mem[i] <= 8'hFF;
                else if (op == OP_PROG && i == int'(tgt_addr))
                    mem[i] <= mem[i] & tgt_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               tog <= 1'b0;
        else if (busy && rd_end)  tog <= ~tog;
    end

    assign rdata = busy ? {~tgt_data[7], tog, 6'b0} : mem[rd_addr];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int ARR_W    = 9,
    parameter int SECT_W   = 6,
    parameter int PROG_CYC = 40,
    parameter int SECT_CYC = 60,
    parameter int CHIP_CYC = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe
);
    localparam int MAX_PS  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
    localparam int MAX_CYC = (MAX_PS > CHIP_CYC) ? MAX_PS : CHIP_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic              rd_act, rd_end, wr_pulse;
    logic [ADDR_W-1:0] cyc_addr;
    logic [7:0]        cyc_data;
    logic              busy, start, done, tog;
    logic [CNT_W-1:0]  start_dur;
    op_t               op;
    logic [ARR_W-1:0]  tgt_addr;
    logic [7:0]        tgt_data;

    flash_bus_if #(.ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .strb_n({ce_n, oe_n, we_n}),
        .addr(addr), .dq_in(dq_in), .rd_act(rd_act), .rd_end(rd_end),
        .wr_pulse(wr_pulse), .cyc_addr(cyc_addr), .cyc_data(cyc_data)
    );

    flash_cmd_fsm #(
        .ADDR_W(ADDR_W), .ARR_W(ARR_W), .CNT_W(CNT_W),
        .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .cyc_addr(cyc_addr),
        .cyc_data(cyc_data), .done(done), .busy(busy), .start(start),
        .start_dur(start_dur), .op(op), .tgt_addr(tgt_addr), .tgt_data(tgt_data)
    );

    flash_busy_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start), .dur(start_dur), .done(done)
    );

    flash_store #(.ARR_W(ARR_W), .SECT_W(SECT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(done), .op(op), .tgt_addr(tgt_addr),
        .tgt_data(tgt_data), .rd_addr(addr[ARR_W-1:0]), .busy(busy),
        .rd_end(rd_end), .tog(tog), .rdata(dq_out)
    );

    assign dq_oe = rd_act;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       we_n,
    input logic       dq_oe,
    input logic [7:0] dq_out,
    input logic       busy,
    input logic       done,
    input logic       tog,
    input logic       rd_end
);
    // R2: output drive only follows a read seen on the raw pins two clocks earlier
    p_oe_needs_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(!ce_n && !oe_n && we_n, 2));

    // R9: low status bits are zero in a busy read
    p_status_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dq_oe) |-> (dq_out[5:0] == 6'd0));

    // R9: toggle inverts after every busy read
    p_toggle_flips_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_end) |=> (tog != $past(tog)));

    // R10: toggle holds while not busy
    p_toggle_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(tog));

    // R8: timer completion only occurs inside the busy state
    p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R8: busy is left only through timer completion
    p_busy_until_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .dq_oe(dq_oe), .dq_out(dq_out), .busy(busy), .done(done), .tog(tog),
    .rd_end(rd_end)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  dq_in = '0;
    logic [7:0]  dq_out;
    logic        dq_oe;

    typedef struct {
        logic [7:0] exp;
        logic       oe_exp;
        string      req;
    } item_t;

    item_t sb[$];
    event  smp_ev;
    int    checks = 0;
    int    errs = 0;
    logic [7:0] mdl [512];
    logic  tog_exp = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    flash_cmd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // monitor: pop and compare at each sample point
    initial begin
        forever begin
            @(smp_ev);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (dq_oe !== it.oe_exp || (it.oe_exp && dq_out !== it.exp)) begin
                    errs++;
                    $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h",
                             it.req, dq_oe, dq_out, it.oe_exp, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    task automatic drv_wr(input logic [14:0] a, input logic [7:0] d, input bit ce_ends);
        @(negedge clk);
        addr = a; dq_in = d; oe_n = 1'b1;
        if (ce_ends) we_n = 1'b0; else ce_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        if (ce_ends) ce_n = 1'b1; else we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_rd(input logic [14:0] a, input logic c, input logic o,
                          input logic [7:0] exp, input logic oe_exp, input string req);
        item_t it;
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = c; oe_n = o;
        repeat (4) @(posedge clk);
        @(negedge clk);
        it.exp = exp; it.oe_exp = oe_exp; it.req = req;
        sb.push_back(it);
        -> smp_ev;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_arr(input logic [14:0] a, input string req);
        bus_rd(a, 1'b0, 1'b0, mdl[a[8:0]], 1'b1, req);
    endtask

    task automatic rd_busy(input logic b7, input string req);
        bus_rd(15'h0, 1'b0, 1'b0, {~b7, tog_exp, 6'b0}, 1'b1, req);
        tog_exp = ~tog_exp;
    endtask

    task automatic prog(input logic [14:0] a, input logic [7:0] d, input bit ce_ends);
        drv_wr(15'h5555, 8'hAA, ce_ends);
        drv_wr(15'h2AAA, 8'h55, ce_ends);
        drv_wr(15'h5555, 8'hA0, ce_ends);
        drv_wr(a, d, ce_ends);
        mdl[a[8:0]] = mdl[a[8:0]] & d;
    endtask

    task automatic ers_prefix();
        drv_wr(15'h5555, 8'hAA, 1'b0);
        drv_wr(15'h2AAA, 8'h55, 1'b0);
        drv_wr(15'h5555, 8'h80, 1'b0);
        drv_wr(15'h5555, 8'hAA, 1'b0);
        drv_wr(15'h2AAA, 8'h55, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mdl[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        checks++;
        if (dq_oe !== 1'b0) begin
            errs++;
            $display("FAIL R1: dq_oe=%0b expected 0 after reset", dq_oe);
        end
        rd_arr(15'h010, "R1 erased after reset");
        bus_rd(15'h010, 1'b0, 1'b1, 8'h00, 1'b0, "R2 OE high not driven");
        bus_rd(15'h010, 1'b1, 1'b0, 8'h00, 1'b0, "R2 CE high not driven");

        // R4/R9: program and poll status
        prog(15'h010, 8'h5A, 1'b0);
        rd_busy(1'b0, "R9 first busy read");
        rd_busy(1'b0, "R9 second busy read toggles");
        repeat (60) @(negedge clk);
        rd_arr(15'h010, "R4 program result");
        rd_arr(15'h010, "R10 stable after done");

        // R3: CE-ended write cycles, AND semantics
        prog(15'h010, 8'hF0, 1'b1);
        rd_busy(1'b1, "R3 R9 busy via CE-ended program");
        repeat (60) @(negedge clk);
        rd_arr(15'h010, "R3 R4 AND program");

        // R8: writes during busy ignored
        prog(15'h050, 8'h33, 1'b0);
        repeat (60) @(negedge clk);
        prog(15'h1C3, 8'h81, 1'b0);
        drv_wr(15'h5555, 8'hAA, 1'b0);
        drv_wr(15'h2AAA, 8'h55, 1'b0);
        drv_wr(15'h5555, 8'hA0, 1'b0);
        repeat (60) @(negedge clk);
        drv_wr(15'h0D0, 8'h00, 1'b0);
        rd_arr(15'h0D0, "R8 busy writes ignored");
        rd_arr(15'h1C3, "R8 program during test");

        // R7: broken sequences
        drv_wr(15'h5555, 8'hAA, 1'b0);
        drv_wr(15'h2AAA, 8'h55, 1'b0);
        drv_wr(15'h5555, 8'h77, 1'b0);
        drv_wr(15'h010, 8'h00, 1'b0);
        rd_arr(15'h010, "R7 bad third cycle");
        ers_prefix();
        drv_wr(15'h050, 8'h31, 1'b0);
        rd_arr(15'h050, "R7 bad erase selector");

        // R5: sector erase of sector 0
        ers_prefix();
        drv_wr(15'h020, 8'h30, 1'b0);
        rd_busy(1'b1, "R9 erase busy status");
        for (int i = 0; i < 64; i++) mdl[i] = 8'hFF;
        repeat (80) @(negedge clk);
        rd_arr(15'h010, "R5 target sector erased");
        rd_arr(15'h050, "R5 neighbour sector kept");
        rd_arr(15'h1C3, "R5 far sector kept");

        // R6: chip erase, final address arbitrary
        ers_prefix();
        drv_wr(15'h1C3, 8'h10, 1'b0);
        for (int i = 0; i < 512; i++) mdl[i] = 8'hFF;
        repeat (100) @(negedge clk);
        rd_arr(15'h050, "R6 chip erase");
        rd_arr(15'h1C3, "R6 chip erase any address");

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule